// File: doc/BRIEF.md
# Exception Entry Sequencer

This block takes the moment a processor decides to take an exception and turns it into the architectural side effects plus a handler address. A request pulse carries a cause code, the PC to resume at, a flag saying whether the faulting instruction sat in a branch delay slot, a flag marking a translation-refill miss, and the current interrupt pending and mask lines. One cycle later the block presents the updated exception PC, the cause code and delay-slot flag, the raised exception-level bit, and the registered handler entry address with a one-cycle valid strobe.

The handler address is a base plus an offset. The base is chosen from the bootstrap-vector setting, the software-programmed exception base, or a forced uncached window for cache errors. The offset separates refill misses, general exceptions and interrupts. Interrupts may be vectored, in which case the highest masked pending line picks a slot whose stride is a programmable spacing. Once the exception level is raised, later requests still update the cause code but leave the saved PC and delay-slot flag alone, so a nested fault cannot overwrite the original return point.

Top module: `exc_entry_unit`

## Requirements
- R1: A request is a single-cycle pulse on `exc_req`; in the following cycle `handler_valid` is 1 and all register outputs show the update. In any cycle not preceded by a request, `handler_valid` is 0.
- R2: When `status_exl` is 0 at the request, `epc` takes `exc_pc` and `cause_bd` takes `exc_in_delay`; when `status_exl` is 1 both keep their values.
- R3: Every request sets `status_exl` to 1, and it stays 1 until reset.
- R4: Every request writes `exc_code` into `cause_code`, whatever the exception level.
- R5: With `boot_vec` = 1 the handler base is `exc_base` + 0x200, for every cause code.
- R6: With `boot_vec` = 0 and a cause code other than 30, the handler base is `ebase` with bits 11..0 cleared.
- R7: With `boot_vec` = 0 and cause code 30 (cache error), the handler base is 0xA0000000 OR (`ebase` AND 0x1FFFF000).
- R8: For a cause code other than 0, the offset is 0 when `exc_refill` = 1 and `status_exl` = 0 at the request, and 0x180 in every other case (including a refill taken with `status_exl` = 1).
- R9: For cause code 0 (interrupt) with `vec_enable` = 1, `boot_vec` = 0 and `vec_spacing` nonzero, the offset is 0x200 + V × (`vec_spacing` × 32), where V is the index of the highest set bit of `irq_pending` AND `irq_mask` (V = 0 when none is set).
- R10: For cause code 0 when `vec_enable` = 0, `boot_vec` = 1 or `vec_spacing` = 0, the offset is 0x200 regardless of the pending and mask lines.
- R11: A synchronous reset (`rst` = 1 at a clock edge) clears `epc`, `cause_code`, `cause_bd`, `status_exl`, `handler_pc` and `handler_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exc_req | input | 1 | Single-cycle exception request |
| exc_code | input | 5 | Cause code of the request (0 interrupt, 30 cache error) |
| exc_pc | input | 32 | PC to resume at |
| exc_in_delay | input | 1 | Faulting instruction is in a branch delay slot |
| exc_refill | input | 1 | Request is a translation-refill miss |
| irq_pending | input | 8 | Interrupt pending lines |
| irq_mask | input | 8 | Interrupt enable mask |
| vec_enable | input | 1 | Vectored interrupt mode |
| vec_spacing | input | 5 | Vector slot spacing in units of 32 bytes |
| boot_vec | input | 1 | Bootstrap vector selection |
| ebase | input | 32 | Software exception base |
| exc_base | input | 32 | Bootstrap exception base |
| epc | output | 32 | Saved resume PC |
| cause_code | output | 5 | Latched cause code |
| cause_bd | output | 1 | Latched branch-delay flag |
| status_exl | output | 1 | Exception level |
| handler_pc | output | 32 | Handler entry address |
| handler_valid | output | 1 | Handler address strobe, one cycle per request |

## Verification
A corrupted exception-level bit shows in the very next request: the saved PC either changes when it should hold or holds when it should change, and a refill request lands on 0x180 instead of 0. A wrong vector index or spacing product appears at `handler_pc` exactly one cycle after the interrupt request, so the sweep over every pending line, mask line and several spacings pins each slot address. A missing or stretched strobe is visible on `handler_valid` in the cycle after the request and the cycle after that.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

   // additive constant for the bootstrap base
   localparam logic [31:0] BOOT_BASE_ADD  = 32'h0000_0200;
   // uncached, unmapped window used for cache-error entry
   localparam logic [31:0] UNCACHED_WIN   = 32'hA000_0000;
   // ebase bits kept when entering through the uncached window
   localparam logic [31:0] CE_EBASE_KEEP  = 32'h1FFF_F000;
   // low ebase bits discarded for the normal base
   localparam int unsigned EBASE_ALIGN_W  = 12;

   localparam int unsigned OFS_REFILL     = 'h000;
   localparam int unsigned OFS_GENERAL    = 'h180;
   localparam int unsigned OFS_IRQ        = 'h200;
   localparam int unsigned SLOT_SHIFT     = 5;

   typedef enum logic [1:0] {
      BASE_BOOT,
      BASE_CACHE_ERR,
      BASE_EBASE
   } base_sel_e;

   typedef enum logic [1:0] {
      OFS_SEL_REFILL,
      OFS_SEL_GENERAL,
      OFS_SEL_IRQ
   } ofs_sel_e;

endpackage

// File: rtl/exc_irq_offset.sv
module exc_irq_offset
   import exc_entry_pkg::*;
#(
   parameter int unsigned IRQ_W    = 8,
   parameter int unsigned SPACE_W  = 5,
   parameter int unsigned OFS_W    = 16,
   parameter bit          VECTORED = 1'b1
) (
   input  logic [IRQ_W-1:0]   pending,
   input  logic [IRQ_W-1:0]   mask,
   input  logic [SPACE_W-1:0] spacing,
   input  logic               vec_en,
   input  logic               boot,
   output logic [OFS_W-1:0]   irq_ofs
);

   localparam int unsigned VEC_W = (IRQ_W > 1) ? $clog2(IRQ_W) : 1;

   generate
      if (VECTORED) begin : g_vectored
         logic [IRQ_W-1:0] live;
         logic [VEC_W-1:0] vec_num;
         logic [OFS_W-1:0] stride;
         logic             use_slots;

         assign live = pending & mask;

         // ascending scan: the last hit is the highest line
         always_comb begin
            vec_num = '0;
            for (int i = 0; i < IRQ_W; i++) begin
               if (live[i]) vec_num = VEC_W'(i);
            end
         end

         assign stride    = OFS_W'(spacing) << SLOT_SHIFT;
         assign use_slots = vec_en && !boot && (spacing != '0);

         always_comb begin
            if (use_slots) irq_ofs = OFS_W'(OFS_IRQ) + OFS_W'(vec_num) * stride;
            else           irq_ofs = OFS_W'(OFS_IRQ);
         end
      end else begin : g_flat
         logic unused_in;
         assign unused_in = ^{pending, mask, spacing, vec_en, boot};
         assign irq_ofs   = OFS_W'(OFS_IRQ);
      end
   endgenerate

endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
   import exc_entry_pkg::*;
#(
   parameter int unsigned ADDR_W         = 32,
   parameter int unsigned CODE_W         = 5,
   parameter int unsigned OFS_W          = 16,
   parameter int unsigned CACHE_ERR_CODE = 30,
   parameter int unsigned IRQ_CODE       = 0
) (
   input  logic [CODE_W-1:0] code,
   input  logic              refill,
   input  logic              exl,
   input  logic              boot,
   input  logic [ADDR_W-1:0] ebase,
   input  logic [ADDR_W-1:0] exc_base,
   input  logic [OFS_W-1:0]  irq_ofs,
   output logic [ADDR_W-1:0] handler
);

   localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'({EBASE_ALIGN_W{1'b1}});

   base_sel_e         bsel;
   ofs_sel_e          osel;
   logic [ADDR_W-1:0] base;
   logic [ADDR_W-1:0] ofs;

   // bootstrap setting outranks the cache-error window
   always_comb begin
      if (boot)                                bsel = BASE_BOOT;
      else if (code == CODE_W'(CACHE_ERR_CODE)) bsel = BASE_CACHE_ERR;
      else                                     bsel = BASE_EBASE;
   end

   always_comb begin
      if (code == CODE_W'(IRQ_CODE)) osel = OFS_SEL_IRQ;
      else if (refill && !exl)       osel = OFS_SEL_REFILL;
      else                           osel = OFS_SEL_GENERAL;
   end

   always_comb begin
      unique case (bsel)
         BASE_BOOT:      base = exc_base + ADDR_W'(BOOT_BASE_ADD);
         BASE_CACHE_ERR: base = ADDR_W'(UNCACHED_WIN) | (ebase & ADDR_W'(CE_EBASE_KEEP));
         default:        base = ebase & ALIGN_MASK;
      endcase
   end

   always_comb begin
      unique case (osel)
         OFS_SEL_REFILL: ofs = ADDR_W'(OFS_REFILL);
         OFS_SEL_IRQ:    ofs = ADDR_W'(irq_ofs);
         default:        ofs = ADDR_W'(OFS_GENERAL);
      endcase
   end

   assign handler = base + ofs;

endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned CODE_W = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req,
   input  logic [CODE_W-1:0] code,
   input  logic [ADDR_W-1:0] pc,
   input  logic              in_delay,
   input  logic [ADDR_W-1:0] handler_nxt,
   output logic [ADDR_W-1:0] epc_q,
   output logic [CODE_W-1:0] code_q,
   output logic              bd_q,
   output logic              exl_q,
   output logic [ADDR_W-1:0] handler_q,
   output logic              valid_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         epc_q     <= '0;
         code_q    <= '0;
         bd_q      <= 1'b0;
         exl_q     <= 1'b0;
         handler_q <= '0;
         valid_q   <= 1'b0;
      end else begin
         valid_q <= req;
         if (req) begin
            exl_q     <= 1'b1;
            code_q    <= code;
            handler_q <= handler_nxt;
            // return point is only captured on the first level of entry
            if (!exl_q) begin
               epc_q <= pc;
               bd_q  <= in_delay;
            end
         end
      end
   end

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit #(
   parameter int unsigned ADDR_W         = 32,
   parameter int unsigned CODE_W         = 5,
   parameter int unsigned IRQ_W          = 8,
   parameter int unsigned SPACE_W        = 5,
   parameter int unsigned CACHE_ERR_CODE = 30,
   parameter int unsigned IRQ_CODE       = 0,
   parameter bit          VECTORED       = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               exc_req,
   input  logic [CODE_W-1:0]  exc_code,
   input  logic [ADDR_W-1:0]  exc_pc,
   input  logic               exc_in_delay,
   input  logic               exc_refill,
   input  logic [IRQ_W-1:0]   irq_pending,
   input  logic [IRQ_W-1:0]   irq_mask,
   input  logic               vec_enable,
   input  logic [SPACE_W-1:0] vec_spacing,
   input  logic               boot_vec,
   input  logic [ADDR_W-1:0]  ebase,
   input  logic [ADDR_W-1:0]  exc_base,
   output logic [ADDR_W-1:0]  epc,
   output logic [CODE_W-1:0]  cause_code,
   output logic               cause_bd,
   output logic               status_exl,
   output logic [ADDR_W-1:0]  handler_pc,
   output logic               handler_valid
);

   localparam int unsigned VEC_W  = (IRQ_W > 1) ? $clog2(IRQ_W) : 1;
   localparam int unsigned PROD_W = SPACE_W + exc_entry_pkg::SLOT_SHIFT + VEC_W;
   localparam int unsigned OFS_W  = ((PROD_W > 10) ? PROD_W : 10) + 1;

   generate
      if (ADDR_W < 32) begin : g_bad_addr
         $error("exc_entry_unit: ADDR_W must be at least 32");
      end
      if ((1 << CODE_W) <= CACHE_ERR_CODE) begin : g_bad_code
         $error("exc_entry_unit: CODE_W too narrow for the cache-error code");
      end
      if ((1 << CODE_W) <= IRQ_CODE) begin : g_bad_irq
         $error("exc_entry_unit: CODE_W too narrow for the interrupt code");
      end
      if (OFS_W > ADDR_W) begin : g_bad_ofs
         $error("exc_entry_unit: offset wider than the address");
      end
   endgenerate

   logic [OFS_W-1:0]  irq_ofs;
   logic [ADDR_W-1:0] handler_nxt;

   exc_irq_offset #(
      .IRQ_W    (IRQ_W),
      .SPACE_W  (SPACE_W),
      .OFS_W    (OFS_W),
      .VECTORED (VECTORED)
   ) u_irq (
      .pending (irq_pending),
      .mask    (irq_mask),
      .spacing (vec_spacing),
      .vec_en  (vec_enable),
      .boot    (boot_vec),
      .irq_ofs (irq_ofs)
   );

   exc_vector_sel #(
      .ADDR_W         (ADDR_W),
      .CODE_W         (CODE_W),
      .OFS_W          (OFS_W),
      .CACHE_ERR_CODE (CACHE_ERR_CODE),
      .IRQ_CODE       (IRQ_CODE)
   ) u_sel (
      .code     (exc_code),
      .refill   (exc_refill),
      .exl      (status_exl),
      .boot     (boot_vec),
      .ebase    (ebase),
      .exc_base (exc_base),
      .irq_ofs  (irq_ofs),
      .handler  (handler_nxt)
   );

   exc_state_regs #(
      .ADDR_W (ADDR_W),
      .CODE_W (CODE_W)
   ) u_regs (
      .clk         (clk),
      .rst         (rst),
      .req         (exc_req),
      .code        (exc_code),
      .pc          (exc_pc),
      .in_delay    (exc_in_delay),
      .handler_nxt (handler_nxt),
      .epc_q       (epc),
      .code_q      (cause_code),
      .bd_q        (cause_bd),
      .exl_q       (status_exl),
      .handler_q   (handler_pc),
      .valid_q     (handler_valid)
   );

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned CODE_W = 5
) (
   input logic              clk,
   input logic              rst,
   input logic              exc_req,
   input logic [CODE_W-1:0] exc_code,
   input logic [ADDR_W-1:0] exc_pc,
   input logic              exc_in_delay,
   input logic [ADDR_W-1:0] epc,
   input logic [CODE_W-1:0] cause_code,
   input logic              cause_bd,
   input logic              status_exl,
   input logic              handler_valid
);

   assert_strobe_follows_R1: assert property (@(posedge clk) disable iff (rst)
      exc_req |=> handler_valid);

   assert_strobe_quiet_R1: assert property (@(posedge clk) disable iff (rst)
      !exc_req |=> !handler_valid);

   assert_capture_first_R2: assert property (@(posedge clk) disable iff (rst)
      (exc_req && !status_exl) |=> (epc == $past(exc_pc)) && (cause_bd == $past(exc_in_delay)));

   assert_hold_nested_R2: assert property (@(posedge clk) disable iff (rst)
      (exc_req && status_exl) |=> $stable(epc) && $stable(cause_bd));

   assert_level_raised_R3: assert property (@(posedge clk) disable iff (rst)
      exc_req |=> status_exl);

   assert_level_sticky_R3: assert property (@(posedge clk) disable iff (rst)
      status_exl |=> status_exl);

   assert_code_written_R4: assert property (@(posedge clk) disable iff (rst)
      exc_req |=> (cause_code == $past(exc_code)));

   assert_reset_clears_R11: assert property (@(posedge clk)
      rst |=> !status_exl && !handler_valid && (epc == '0) && (cause_code == '0) && !cause_bd);

endmodule

bind exc_entry_unit exc_entry_chk #(
   .ADDR_W (ADDR_W),
   .CODE_W (CODE_W)
) u_chk (
   .clk           (clk),
   .rst           (rst),
   .exc_req       (exc_req),
   .exc_code      (exc_code),
   .exc_pc        (exc_pc),
   .exc_in_delay  (exc_in_delay),
   .epc           (epc),
   .cause_code    (cause_code),
   .cause_bd      (cause_bd),
   .status_exl    (status_exl),
   .handler_valid (handler_valid)
);

// File: tb/exc_entry_unit_tb.sv
`timescale 1ns/1ps
module exc_entry_unit_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        exc_req = 1'b0;
   logic [4:0]  exc_code = '0;
   logic [31:0] exc_pc = '0;
   logic        exc_in_delay = 1'b0;
   logic        exc_refill = 1'b0;
   logic [7:0]  irq_pending = '0;
   logic [7:0]  irq_mask = '0;
   logic        vec_enable = 1'b0;
   logic [4:0]  vec_spacing = '0;
   logic        boot_vec = 1'b0;
   logic [31:0] ebase = 32'h8000_0000;
   logic [31:0] exc_base = 32'hBFC0_0000;
   logic [31:0] epc;
   logic [4:0]  cause_code;
   logic        cause_bd;
   logic        status_exl;
   logic [31:0] handler_pc;
   logic        handler_valid;

   int checks = 0;
   int errors = 0;

   logic        m_exl = 1'b0;
   logic [31:0] m_epc = '0;
   logic        m_bd  = 1'b0;

   always #4 clk = ~clk;

   exc_entry_unit u_dut (
      .clk (clk), .rst (rst), .exc_req (exc_req), .exc_code (exc_code),
      .exc_pc (exc_pc), .exc_in_delay (exc_in_delay), .exc_refill (exc_refill),
      .irq_pending (irq_pending), .irq_mask (irq_mask), .vec_enable (vec_enable),
      .vec_spacing (vec_spacing), .boot_vec (boot_vec), .ebase (ebase),
      .exc_base (exc_base), .epc (epc), .cause_code (cause_code),
      .cause_bd (cause_bd), .status_exl (status_exl), .handler_pc (handler_pc),
      .handler_valid (handler_valid)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // expected handler address, built from R5..R10
   function automatic logic [31:0] exp_handler();
      logic [31:0] b, o;
      int v;
      if (boot_vec)            b = exc_base + 32'h200;                      // R5
      else if (exc_code == 30) b = 32'hA000_0000 | (ebase & 32'h1FFF_F000); // R7
      else                     b = {ebase[31:12], 12'h000};                 // R6
      if (exc_code == 0) begin
         v = 0;
         for (int i = 7; i >= 0; i--) begin
            if (irq_pending[i] && irq_mask[i] && v == 0) v = i;
         end
         if (vec_enable && !boot_vec && vec_spacing != 0)
            o = 32'h200 + v * (vec_spacing * 32);                          // R9
         else
            o = 32'h200;                                                   // R10
      end else if (exc_refill && !m_exl) o = 32'h0;                         // R8
      else                               o = 32'h180;                       // R8
      return b + o;
   endfunction

   task automatic do_reset();
      rst = 1'b1;
      exc_req = 1'b0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      m_exl = 1'b0;
      m_epc = '0;
      m_bd  = 1'b0;
   endtask

   // issue one request from a negedge and check both following cycles
   task automatic fire(string tag);
      logic [31:0] eh;
      eh = exp_handler();
      if (!m_exl) begin
         m_epc = exc_pc;
         m_bd  = exc_in_delay;
      end
      exc_req = 1'b1;
      @(negedge clk);
      exc_req = 1'b0;
      chk({tag, " R1 valid"}, {31'b0, handler_valid}, 32'd1);
      chk({tag, " handler"}, handler_pc, eh);
      chk({tag, " R2 epc"}, epc, m_epc);
      chk({tag, " R2 bd"}, {31'b0, cause_bd}, {31'b0, m_bd});
      chk({tag, " R3 exl"}, {31'b0, status_exl}, 32'd1);
      chk({tag, " R4 code"}, {27'b0, cause_code}, {27'b0, exc_code});
      m_exl = 1'b1;
      @(negedge clk);
      chk({tag, " R1 strobe drop"}, {31'b0, handler_valid}, 32'd0);
   endtask

   initial begin
      #(8 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      do_reset();
      // R11 reset state
      chk("R11 epc", epc, 32'h0);
      chk("R11 code", {27'b0, cause_code}, 32'h0);
      chk("R11 exl", {31'b0, status_exl}, 32'h0);
      chk("R11 bd", {31'b0, cause_bd}, 32'h0);
      chk("R11 handler", handler_pc, 32'h0);
      chk("R11 valid", {31'b0, handler_valid}, 32'h0);

      // R6 R8 general exception, first level
      ebase = 32'h8123_4ABC; exc_code = 5'd8; exc_pc = 32'h0040_1000; exc_in_delay = 1'b1;
      fire("R6 R8 general");
      // R2 nested: epc/bd held, code updated, refill at exl=1 uses 0x180
      exc_code = 5'd2; exc_refill = 1'b1; exc_pc = 32'h0040_2000; exc_in_delay = 1'b0;
      fire("R2 R8 nested refill");

      // R8 refill at exl=0
      do_reset();
      exc_pc = 32'h0000_3000;
      fire("R8 refill first");
      exc_refill = 1'b0;

      // R5 bootstrap base, general and cache-error codes
      do_reset();
      boot_vec = 1'b1; exc_code = 5'd4;
      fire("R5 boot general");
      exc_code = 5'd30;
      fire("R5 boot cache err");
      boot_vec = 1'b0;

      // R7 cache error through the uncached window
      do_reset();
      ebase = 32'hFFFF_F123; exc_code = 5'd30;
      fire("R7 cache err a");
      ebase = 32'h9000_5000;
      fire("R7 cache err b");

      // R9 R10 interrupt sweep
      do_reset();
      ebase = 32'h8000_1000; exc_code = 5'd0;
      for (int vm = 0; vm < 2; vm++) begin
         for (int si = 0; si < 4; si++) begin
            for (int ln = 0; ln < 8; ln++) begin
               vec_enable  = vm[0];
               vec_spacing = (si == 3) ? 5'd31 : 5'(si);
               irq_pending = 8'(1 << ln) | 8'h01;
               irq_mask    = 8'hFF;
               fire(vm ? "R9 vec pend" : "R10 flat pend");
               irq_pending = 8'hFF;
               irq_mask    = 8'(1 << ln);
               fire(vm ? "R9 vec mask" : "R10 flat mask");
            end
         end
      end

      // R10 boot overrides vectoring, empty masked lines give slot 0
      vec_enable = 1'b1; vec_spacing = 5'd3; irq_pending = 8'h80; irq_mask = 8'hFF;
      boot_vec = 1'b1;
      fire("R10 boot irq");
      boot_vec = 1'b0; irq_mask = 8'h00;
      fire("R10 masked irq");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule